// File: doc/BRIEF.md
# Timer clock gate, source select and prescale unit

This unit produces the counting enables for a group of timer channels: a configurable number of general timers (up to eight), an optional OS-timer channel and a watchdog channel. Three level inputs act as candidate source clocks: a peripheral clock, a real-time clock and an external clock. Each is brought into the bus clock domain through a two-flop synchronizer. Each channel picks one source, divides the rising edges of that source by a power of four, and emits a one-bus-cycle tick each time its prescale counter wraps.

Software controls the unit through a small register map. A shared stop word holds one stop bit per channel. It is read at one address and changed through separate write-one-to-set and write-one-to-clear addresses. Each channel has a 16-bit control word. Software can change a control word only while that channel is running.

Address map (word addresses, `wr_addr_i` and `rd_addr_i`): 0 = stop status (read), 1 = stop set (write), 2 = stop clear (write), 32+b = control word of the channel whose gate bit is b.

Top module: `tcu_clkgate`

## Requirements
- R1: After reset, every implemented stop bit is 1. Every control word reads 0. No tick is produced whatever the source inputs do.
- R2: Writing address 2 clears the stop bits at the positions where the written data is 1. Bits written as 0 keep their value.
- R3: Writing address 1 sets the stop bits at the positions where the written data is 1. Bits written as 0 keep their value.
- R4: Reading address 0 returns the stop bits, where 1 means stopped and 0 means running. Bit positions with no channel always read 0 and ignore writes.
- R5: A control-word write to a channel whose stop bit is 1 is ignored, and the stored word reads back unchanged. A write to a running channel stores all 16 bits.
- R6: Control bits 2:0 select the source one-hot: bit 0 selects src_i[0], bit 1 selects src_i[1] and bit 2 selects src_i[2]. If several bits are set, the lowest one wins. With none set, the channel never ticks.
- R7: Control bits 5:3 hold n, and the channel ticks once per 4^n rising edges of its source (1, 4, 16, 64, 256, 1024). Values 6 and 7 act as 5.
- R8: A tick lasts exactly one bus cycle. A channel whose stop bit is 1 produces no tick, and its prescale count restarts from zero.
- R9: An accepted control-word write restarts the channel's prescale count from zero.
- R10: General timer k uses gate bit k, the OS timer uses gate bit 15 and the watchdog uses gate bit 16. The same index applies to the stop word, to tick_o and to the control address 32+bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 6 | Register read word address |
| rd_data_o | output | 32 | Read data, registered one cycle after the address |
| src_i | input | 3 | Source clock levels: peripheral, real-time, external |
| tick_o | output | 17 | Per-gate-bit single-cycle count enables |

## Verification
The hardest situation to reach is the top prescale ratio and the saturation of the codes 6 and 7. Observing either one needs more than a thousand synchronized source edges on a running channel, with the count neither restarted by a control write nor cleared by a stop. The bench drives 1023 source pulses and checks that no tick has appeared. It then drives one more pulse and checks for exactly one tick. A second hard case is the restart of the prescale count on a control rewrite. The bench leaves a partial count in place, rewrites the same word, and shows that the expected tick does not arrive.

// File: rtl/tcu_clkgate_pkg.sv
package tcu_clkgate_pkg;
  localparam int NGATE   = 17;
  localparam int OS_BIT  = 15;
  localparam int WDT_BIT = 16;
  localparam int NSRC    = 3;
  localparam int MAX_PS  = 5;
  localparam int CNT_W   = 2 * MAX_PS;

  localparam logic [5:0] A_STAT = 6'd0;
  localparam logic [5:0] A_SET  = 6'd1;
  localparam logic [5:0] A_CLR  = 6'd2;

  function automatic logic [NGATE-1:0] impl_mask(input int ntim, input bit has_os);
    logic [NGATE-1:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) if (i < ntim) m[i] = 1'b1;
    m[OS_BIT]  = has_os;
    m[WDT_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tcu_src_sync.sv
module tcu_src_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= lvl_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  p_rise_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/tcu_chan.sv
module tcu_chan
  import tcu_clkgate_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   rise_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              tick_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tick_q;
  logic              sel_rise;
  logic [2:0]        ps_eff;
  logic [CNT_W-1:0]  wrap_at;

  always_comb begin
    if (ctrl_q[0])      sel_rise = rise_i[0];
    else if (ctrl_q[1]) sel_rise = rise_i[1];
    else if (ctrl_q[2]) sel_rise = rise_i[2];
    else                sel_rise = 1'b0;
  end

  always_comb begin
    ps_eff  = (ctrl_q[5:3] > 3'(MAX_PS)) ? 3'(MAX_PS) : ctrl_q[5:3];
    wrap_at = CNT_W'((32'd1 << (2 * ps_eff)) - 32'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (!run_i) begin
        cnt_q <= '0;
      end else if (wr_i) begin
        ctrl_q <= wdata_i;
        cnt_q  <= '0;
      end else if (sel_rise) begin
        if (cnt_q == wrap_at) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign tick_o = tick_q;

  p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
  p_no_tick_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !tick_q);
  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(ctrl_q));
  p_no_source_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[2:0] == 3'b000) |=> !tick_q);
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= wrap_at);
  p_wr_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (run_i && wr_i) |=> (cnt_q == '0 && !tick_q));
endmodule

// File: rtl/tcu_clkgate.sv
module tcu_clkgate
  import tcu_clkgate_pkg::*;
#(
  parameter int N_TIMERS = 8,
  parameter bit HAS_OS   = 1'b1,
  parameter int DATA_W   = 32,
  parameter int CTRL_W   = 16,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NSRC-1:0]   src_i,
  output logic [NGATE-1:0]  tick_o
);
  localparam logic [NGATE-1:0] MASK = impl_mask(N_TIMERS, HAS_OS);
  localparam int NSLOT = 32;

  logic [NGATE-1:0]  stop_q;
  logic [NGATE-1:0]  wbits;
  logic [NSRC-1:0]   rise;
  logic [CTRL_W-1:0] ctrl_all [NSLOT];
  logic              ctrl_wr;

  assign wbits   = wr_data_i[NGATE-1:0] & MASK;
  assign ctrl_wr = wr_en_i && wr_addr_i[5];

  tcu_src_sync #(.W(NSRC)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= MASK;
    end else if (wr_en_i && wr_addr_i == A_SET) begin
      stop_q <= stop_q | wbits;
    end else if (wr_en_i && wr_addr_i == A_CLR) begin
      stop_q <= stop_q & ~wbits;
    end
  end

  for (genvar b = 0; b < NSLOT; b++) begin : g_slot
    if (b < NGATE && MASK[b % NGATE]) begin : g_chan
      logic tk;
      tcu_chan #(.CTRL_W(CTRL_W)) u_chan (
        .clk     (clk),
        .rst     (rst),
        .run_i   (!stop_q[b]),
        .wr_i    (ctrl_wr && wr_addr_i[4:0] == 5'(b)),
        .wdata_i (wr_data_i[CTRL_W-1:0]),
        .rise_i  (rise),
        .ctrl_o  (ctrl_all[b]),
        .tick_o  (tk)
      );
      assign tick_o[b] = tk;
    end else begin : g_none
      assign ctrl_all[b] = '0;
      if (b < NGATE) begin : g_tie
        assign tick_o[b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_addr_i == A_STAT) begin
      rd_data_o <= DATA_W'(stop_q);
    end else if (rd_addr_i[5]) begin
      rd_data_o <= DATA_W'(ctrl_all[rd_addr_i[4:0]]);
    end else begin
      rd_data_o <= '0;
    end
  end

  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == A_SET) |=>
      ((stop_q & $past(wbits)) == $past(wbits)) &&
      ((stop_q & ~$past(wbits)) == ($past(stop_q) & ~$past(wbits))));
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == A_CLR) |=>
      ((stop_q & $past(wbits)) == '0) &&
      ((stop_q & ~$past(wbits)) == ($past(stop_q) & ~$past(wbits))));
  p_unimpl_r4: assert property (@(posedge clk) disable iff (rst)
    ((stop_q & ~MASK) == '0) && ((tick_o & ~MASK) == '0));
endmodule

// File: tb/tcu_clkgate_tb_top.sv
module tcu_clkgate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  src = '0;
  logic [16:0] tick;

  int checks = 0;
  int errors = 0;
  int tcnt [17];

  always #5 clk = ~clk;

  tcu_clkgate dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .src_i     (src),
    .tick_o    (tick)
  );

  always @(negedge clk)
    for (int b = 0; b < 17; b++) if (tick[b]) tcnt[b]++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src[s] = 1'b1;
      @(negedge clk);
      @(negedge clk); src[s] = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic zero_counts();
    for (int b = 0; b < 17; b++) tcnt[b] = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'd0, d);  chk("R1 status after reset", d, 32'h0001_80FF);
    rd(6'd32, d); chk("R1 ctrl0 after reset", d, 32'h0);
    rd(6'd48, d); chk("R1 wdt ctrl after reset", d, 32'h0);
    zero_counts();
    pulse(0, 3); pulse(1, 3); pulse(2, 3);
    chk("R1 no ticks after reset", 32'(tick == '0 && tcnt[0] == 0 && tcnt[16] == 0), 32'd1);
  endtask

  task automatic t_stopbits();
    logic [31:0] d;
    wr(6'd2, 32'hFFFF_FFFF);
    rd(6'd0, d); chk("R2 clear all", d, 32'h0);
    wr(6'd1, 32'h0000_7F00);
    rd(6'd0, d); chk("R4 unimplemented bits read 0", d, 32'h0);
    wr(6'd1, 32'h0000_0005);
    rd(6'd0, d); chk("R3 set only ones", d, 32'h5);
    wr(6'd1, 32'h0000_0002);
    rd(6'd0, d); chk("R3 zeros keep set bits", d, 32'h7);
    wr(6'd2, 32'h0000_0004);
    rd(6'd0, d); chk("R2 clear only ones", d, 32'h3);
    wr(6'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignore_stopped();
    logic [31:0] d;
    wr(6'd1, 32'h10);
    wr(6'd36, 32'h0001);
    rd(6'd36, d); chk("R5 write ignored while stopped", d, 32'h0);
    wr(6'd2, 32'h10);
    wr(6'd36, 32'hA5C1);
    rd(6'd36, d); chk("R5 write stored while running", d, 32'hA5C1);
  endtask

  task automatic t_ratio1();
    wr(6'd32, 32'h0001);
    zero_counts();
    pulse(0, 5);
    chk("R7 ratio 1 on src0 ch0", tcnt[0], 5);
  endtask

  task automatic t_ratio4_select();
    wr(6'd33, 32'h000E);
    zero_counts();
    pulse(2, 8);
    chk("R6 lowest set bit wins: src2 ignored", tcnt[1], 0);
    pulse(1, 9);
    chk("R7 ratio 4 on src1 ch1", tcnt[1], 2);
  endtask

  task automatic t_no_source();
    wr(6'd35, 32'h0028);
    zero_counts();
    pulse(0, 2); pulse(1, 2); pulse(2, 2);
    chk("R6 no source bit gives no ticks", tcnt[3], 0);
  endtask

  task automatic t_restart();
    wr(6'd32, 32'h0009);
    zero_counts();
    pulse(0, 3);
    chk("R9 partial count no tick", tcnt[0], 0);
    wr(6'd32, 32'h0009);
    pulse(0, 3);
    chk("R9 rewrite restarts count", tcnt[0], 0);
    pulse(0, 1);
    chk("R9 tick after full count", tcnt[0], 1);
  endtask

  task automatic t_stop_gate();
    wr(6'd32, 32'h0001);
    wr(6'd1, 32'h1);
    zero_counts();
    pulse(0, 4);
    chk("R8 stopped channel no ticks", tcnt[0], 0);
    wr(6'd2, 32'h1);
    pulse(0, 2);
    chk("R8 running again ticks", tcnt[0], 2);
  endtask

  task automatic t_ratio16();
    wr(6'd34, 32'h0011);
    zero_counts();
    pulse(0, 33);
    chk("R7 ratio 16 on ch2", tcnt[2], 2);
  endtask

  task automatic t_saturate();
    wr(6'd34, 32'h0039);
    zero_counts();
    pulse(0, 1023);
    chk("R7 code 7 no tick before 1024", tcnt[2], 0);
    pulse(0, 1);
    chk("R7 code 7 acts as 1024", tcnt[2], 1);
  endtask

  task automatic t_special_bits();
    wr(6'd48, 32'h0002);
    wr(6'd47, 32'h000C);
    zero_counts();
    pulse(1, 3);
    chk("R10 watchdog ticks on bit 16", tcnt[16], 3);
    pulse(2, 8);
    chk("R10 OS timer ticks on bit 15", tcnt[15], 2);
    chk("R10 unused tick bits idle", tcnt[8] + tcnt[14], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    zero_counts();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tick idle after reset", 32'(tick), 32'h0);
    t_reset();
    t_stopbits();
    t_ignore_stopped();
    t_ratio1();
    t_ratio4_select();
    t_no_source();
    t_restart();
    t_stop_gate();
    t_ratio16();
    t_saturate();
    t_special_bits();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule